// File: doc/BRIEF.md
# Banked Socket Register Front End

This block is the host-facing register file of a card-slot controller that serves up to four sockets. The host reaches every register through two byte ports. Port offset 0 holds an index. Port offset 1 reads or writes the register that the index selects. The index space is cut into one bank of 64 entries per socket, so offset `r` of socket `s` sits at index `r + 64*s`.

Each bank holds the following registers:
- a read-only view of the socket's sense pins;
- a power byte;
- a control byte, which carries the card-type bit and an inverted reset bit;
- an event-enable byte;
- a 16-bit word;
- a change register that latches detect, sense-pin and ready events and clears when read.

The interrupt output is raised while any populated socket has an enabled event latched. A two-bit configuration input chooses how many sockets exist. Banks beyond that count read as zero, ignore writes and latch no events.

Top module: `slot_regfile`

## Requirements
- R1: A write at port offset 0 loads the 8-bit index. A read at port offset 0 returns the last index written.
- R2: At port offset 1, index bits [7:6] select the socket and bits [5:0] select the register. The registers are: 0x01 pin status (read-only), 0x02 power, 0x03 control, 0x04 change, 0x05 event enable, 0x08/0x09 word. Every other offset reads 0x00 and ignores writes.
- R3: The 16-bit word keeps its low byte at offset 0x08 and its high byte at offset 0x09. Each byte is read and written on its own.
- R4: The pin status register holds the following bits: bit0 sense1, bit1 sense2, bit2 detect1, bit3 detect2, bit4 write-protect, bit5 ready, bit6 power bit4, bit7 zero. A card is present only when bits 2 and 3 are both 1. Change bit3 latches whenever presence flips, in either direction.
- R5: A data-port read of the change register returns its value and clears it. An event that arrives in the same cycle as the read stays latched.
- R6: When control bit5 is 1 (I/O card), only change bit0 latches from the sense pins. It latches on a falling edge of sense1, as a status-change request. When control bit5 is 0 (memory card), bit0 latches on a falling edge of sense1 (battery dead), bit1 on a falling edge of sense2 (battery warning), and bit2 on a rising edge of ready.
- R7: The sense pins are active low. The status bits show the raw pin level, so 0 means the condition is asserted, and sense events fire on the high-to-low transition.
- R8: The socket count follows `cfg_sockets_i`: 00 gives two sockets, 01 gives one socket, and 1x gives four sockets.
- R9: A bank whose socket number is not below the count reads 0x00, ignores writes, latches no events and raises no interrupt.
- R10: `card_rst_o[s]` is 1 while control bit7 of socket s is 0.
- R11: `irq_o` is 1 exactly when some populated socket has a nonzero value of (change AND event enable).
- R12: After reset, the index and all writable and change registers are 0x00. `irq_o` is 0 and every `card_rst_o` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_sockets_i | input | 2 | Socket count selection |
| bus_sel_i | input | 1 | Host access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | Port offset: 0 index, 1 data |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed port |
| sense1_i | input | MAX_SOCK | Active-low sense pin 1 per socket |
| sense2_i | input | MAX_SOCK | Active-low sense pin 2 per socket |
| det1_i | input | MAX_SOCK | Card detect 1 per socket |
| det2_i | input | MAX_SOCK | Card detect 2 per socket |
| wprot_i | input | MAX_SOCK | Write-protect pin per socket |
| ready_i | input | MAX_SOCK | Ready pin per socket |
| card_rst_o | output | MAX_SOCK | Card reset per socket |
| irq_o | output | 1 | Event interrupt |

## Verification
The hardest case to reach is a change-register read whose clearing collides with a new edge on a sense pin. In that cycle the returned byte must not show the event, yet the event must survive into the next read. The bench first primes the pin to its inactive level. It then drops the pin in the very cycle of the data-port read and reads again. The bench also has to show that events stay masked while a bank is unpopulated. It enables events on a socket while all four sockets exist, then lowers the count, toggles that socket's detect pins, and later restores the count to check that nothing was latched.

// File: rtl/slot_pkg.sv
package slot_pkg;
  localparam int unsigned IDX_W = 8;
  localparam int unsigned OFF_W = 6;

  localparam logic [OFF_W-1:0] OFF_STAT = 6'h01;
  localparam logic [OFF_W-1:0] OFF_PWR  = 6'h02;
  localparam logic [OFF_W-1:0] OFF_CTL  = 6'h03;
  localparam logic [OFF_W-1:0] OFF_CHG  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_CEN  = 6'h05;
  localparam logic [OFF_W-1:0] OFF_WLO  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_WHI  = 6'h09;

  localparam int unsigned CTL_IO  = 5;
  localparam int unsigned CTL_RUN = 7;
  localparam int unsigned PWR_OE  = 4;

  localparam int unsigned CHG_B0  = 0;
  localparam int unsigned CHG_B1  = 1;
  localparam int unsigned CHG_RDY = 2;
  localparam int unsigned CHG_DET = 3;

  function automatic logic [2:0] sock_count(input logic [1:0] cfg);
    if (cfg[1])      return 3'd4;
    else if (cfg[0]) return 3'd1;
    else             return 3'd2;
  endfunction
endpackage

// File: rtl/slot_change.sv
module slot_change
  import slot_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       io_mode_i,
  input  logic       sense1_i,
  input  logic       sense2_i,
  input  logic       ready_i,
  input  logic       present_i,
  input  logic       rd_clr_i,
  output logic [7:0] chg_o
);
  logic       s1_q, s2_q, rdy_q, pres_q;
  logic [7:0] ev, chg_q;

  always_comb begin
    ev          = '0;
    ev[CHG_DET] = present_i ^ pres_q;
    ev[CHG_B0]  = s1_q & ~sense1_i;
    ev[CHG_B1]  = ~io_mode_i & s2_q & ~sense2_i;
    ev[CHG_RDY] = ~io_mode_i & ~rdy_q & ready_i;
    if (!en_i) ev = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      rdy_q  <= 1'b0;
      pres_q <= 1'b0;
      chg_q  <= '0;
    end else begin
      s1_q   <= sense1_i;
      s2_q   <= sense2_i;
      rdy_q  <= ready_i;
      pres_q <= present_i;
      chg_q  <= (rd_clr_i ? 8'h00 : chg_q) | ev;
    end
  end

  assign chg_o = chg_q;

  // R5: a read with no new event leaves the register empty
  a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !(sense1_i == 1'b0 && s1_q) && (present_i == pres_q)
     && !(s2_q && !sense2_i) && !(!rdy_q && ready_i)) |=> (chg_q == 8'h00));

  // R6: in I/O mode the battery and ready bits never become set
  a_r6_io_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_mode_i && chg_q[2:1] == 2'b00) |=> (chg_q[2:1] == 2'b00));

  // R9: an unpopulated bank gains no new bits
  a_r9_no_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && chg_q == 8'h00) |=> (chg_q == 8'h00));
endmodule

// File: rtl/slot_bank.sv
module slot_bank
  import slot_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pop_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [7:0]       wdata_i,
  input  logic             sense1_i,
  input  logic             sense2_i,
  input  logic             det1_i,
  input  logic             det2_i,
  input  logic             wprot_i,
  input  logic             ready_i,
  output logic [7:0]       rdata_o,
  output logic             card_rst_o,
  output logic             irq_o
);
  logic [7:0] pwr_q, ctl_q, cen_q, wlo_q, whi_q, chg, stat;
  logic       wr_en, rd_clr;

  assign wr_en  = wr_i & pop_i;
  assign rd_clr = rd_i & pop_i & (off_i == OFF_CHG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q <= '0;
      ctl_q <= '0;
      cen_q <= '0;
      wlo_q <= '0;
      whi_q <= '0;
    end else if (wr_en) begin
      case (off_i)
        OFF_PWR: pwr_q <= wdata_i;
        OFF_CTL: ctl_q <= wdata_i;
        OFF_CEN: cen_q <= wdata_i;
        OFF_WLO: wlo_q <= wdata_i;
        OFF_WHI: whi_q <= wdata_i;
        default: ;
      endcase
    end
  end

  slot_change u_chg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (pop_i),
    .io_mode_i (ctl_q[CTL_IO]),
    .sense1_i  (sense1_i),
    .sense2_i  (sense2_i),
    .ready_i   (ready_i),
    .present_i (det1_i & det2_i),
    .rd_clr_i  (rd_clr),
    .chg_o     (chg)
  );

  assign stat = {1'b0, pwr_q[PWR_OE], ready_i, wprot_i, det2_i, det1_i, sense2_i, sense1_i};

  always_comb begin
    rdata_o = '0;
    if (pop_i) begin
      case (off_i)
        OFF_STAT: rdata_o = stat;
        OFF_PWR:  rdata_o = pwr_q;
        OFF_CTL:  rdata_o = ctl_q;
        OFF_CHG:  rdata_o = chg;
        OFF_CEN:  rdata_o = cen_q;
        OFF_WLO:  rdata_o = wlo_q;
        OFF_WHI:  rdata_o = whi_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign card_rst_o = ~ctl_q[CTL_RUN];
  assign irq_o      = pop_i & (|(chg & cen_q));

  // R10: writing a zero run bit holds the card in reset
  a_r10_reset_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && off_i == OFF_CTL && !wdata_i[CTL_RUN]) |=> card_rst_o);

  // R3: the low-byte write leaves the high byte untouched
  a_r3_byte_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && off_i == OFF_WLO) |=> $stable(whi_q));
endmodule

// File: rtl/slot_regfile.sv
module slot_regfile
  import slot_pkg::*;
#(
  parameter int unsigned MAX_SOCK = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          cfg_sockets_i,
  input  logic                bus_sel_i,
  input  logic                bus_wr_i,
  input  logic                bus_addr_i,
  input  logic [7:0]          bus_wdata_i,
  output logic [7:0]          bus_rdata_o,
  input  logic [MAX_SOCK-1:0] sense1_i,
  input  logic [MAX_SOCK-1:0] sense2_i,
  input  logic [MAX_SOCK-1:0] det1_i,
  input  logic [MAX_SOCK-1:0] det2_i,
  input  logic [MAX_SOCK-1:0] wprot_i,
  input  logic [MAX_SOCK-1:0] ready_i,
  output logic [MAX_SOCK-1:0] card_rst_o,
  output logic                irq_o
);
  localparam int unsigned BANK_W = IDX_W - OFF_W;

  logic [IDX_W-1:0]  idx_q;
  logic [BANK_W-1:0] bank_sel;
  logic [OFF_W-1:0]  off;
  logic [2:0]        cnt;
  logic              wr_dat, rd_dat, pop_sel;
  logic [7:0]        bank_rd [MAX_SOCK];
  logic [7:0]        data_rd;
  logic [MAX_SOCK-1:0] pop, bank_irq;

  assign bank_sel = idx_q[IDX_W-1:OFF_W];
  assign off      = idx_q[OFF_W-1:0];
  assign cnt      = sock_count(cfg_sockets_i);
  assign wr_dat   = bus_sel_i & bus_wr_i & bus_addr_i;
  assign rd_dat   = bus_sel_i & ~bus_wr_i & bus_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 idx_q <= '0;
    else if (bus_sel_i & bus_wr_i & ~bus_addr_i) idx_q <= bus_wdata_i;
  end

  for (genvar s = 0; s < MAX_SOCK; s++) begin : g_bank
    assign pop[s] = (3'(s) < cnt);
    slot_bank u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pop_i      (pop[s]),
      .wr_i       (wr_dat & (bank_sel == BANK_W'(s))),
      .rd_i       (rd_dat & (bank_sel == BANK_W'(s))),
      .off_i      (off),
      .wdata_i    (bus_wdata_i),
      .sense1_i   (sense1_i[s]),
      .sense2_i   (sense2_i[s]),
      .det1_i     (det1_i[s]),
      .det2_i     (det2_i[s]),
      .wprot_i    (wprot_i[s]),
      .ready_i    (ready_i[s]),
      .rdata_o    (bank_rd[s]),
      .card_rst_o (card_rst_o[s]),
      .irq_o      (bank_irq[s])
    );
  end

  always_comb begin
    data_rd = '0;
    pop_sel = 1'b0;
    for (int s = 0; s < MAX_SOCK; s++) begin
      if (bank_sel == BANK_W'(s)) begin
        data_rd = bank_rd[s];
        pop_sel = pop[s];
      end
    end
  end

  assign bus_rdata_o = bus_addr_i ? data_rd : idx_q;
  assign irq_o       = |bank_irq;

  // R1: index load
  a_r1_index_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && bus_wr_i && !bus_addr_i) |=> (idx_q == $past(bus_wdata_i)));

  // R9: unpopulated bank reads zero
  a_r9_unpop_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i && !pop_sel) |-> (bus_rdata_o == 8'h00));

  // R8: single-socket configuration never sees bank 1 populated
  a_r8_one_sock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_sockets_i == 2'b01) |-> (pop[1] == 1'b0));
endmodule

// File: tb/slot_regfile_tb_top.sv
module slot_regfile_tb_top;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg = 2'b10;
  logic sel = 0, wr = 0, addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [NS-1:0] s1 = '1, s2 = '1, d1 = '0, d2 = '0, wp = '0, rdy = '0;
  logic [NS-1:0] crst;
  logic irq;

  int errors = 0, checks = 0;
  bit done = 0;
  string cur_req = "R12";

  // reference model state
  int m_idx;
  int m_pw[NS], m_ctl[NS], m_chg[NS], m_en[NS], m_wlo[NS], m_whi[NS];
  bit p_s1[NS], p_s2[NS], p_rdy[NS], p_pres[NS];

  always #5 clk = ~clk;

  slot_regfile #(.MAX_SOCK(NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_sockets_i(cfg),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .sense1_i(s1), .sense2_i(s2), .det1_i(d1), .det2_i(d2),
    .wprot_i(wp), .ready_i(rdy), .card_rst_o(crst), .irq_o(irq)
  );

  function automatic bit m_pop(int s);
    int n;
    n = cfg[1] ? 4 : (cfg[0] ? 1 : 2);
    return s < n;
  endfunction

  function automatic int m_read(int i);
    int b, r;
    b = i / 64; r = i % 64;
    if (!m_pop(b)) return 0;
    case (r)
      1: return {1'b0, m_pw[b][4], rdy[b], wp[b], d2[b], d1[b], s2[b], s1[b]};
      2: return m_pw[b];
      3: return m_ctl[b];
      4: return m_chg[b];
      5: return m_en[b];
      8: return m_wlo[b];
      9: return m_whi[b];
      default: return 0;
    endcase
  endfunction

  function automatic bit m_irq();
    for (int s = 0; s < NS; s++) if (m_pop(s) && (m_chg[s] & m_en[s]) != 0) return 1;
    return 0;
  endfunction

  task automatic m_reset();
    m_idx = 0;
    for (int s = 0; s < NS; s++) begin
      m_pw[s] = 0; m_ctl[s] = 0; m_chg[s] = 0; m_en[s] = 0; m_wlo[s] = 0; m_whi[s] = 0;
      p_s1[s] = 1; p_s2[s] = 1; p_rdy[s] = 0; p_pres[s] = 0;
    end
  endtask

  task automatic m_step();
    int b, r, ev;
    bit io, pres;
    b = m_idx / 64; r = m_idx % 64;
    for (int s = 0; s < NS; s++) begin
      io = m_ctl[s][5];
      pres = d1[s] & d2[s];
      ev = 0;
      if (m_pop(s)) begin
        if (pres != p_pres[s]) ev |= 8;
        if (p_s1[s] && !s1[s]) ev |= 1;
        if (!io && p_s2[s] && !s2[s]) ev |= 2;
        if (!io && !p_rdy[s] && rdy[s]) ev |= 4;
      end
      if (sel && !wr && addr && b == s && r == 4 && m_pop(s)) m_chg[s] = 0;
      m_chg[s] |= ev;
      p_s1[s] = s1[s]; p_s2[s] = s2[s]; p_rdy[s] = rdy[s]; p_pres[s] = pres;
    end
    if (sel && wr && !addr) m_idx = wdata;
    else if (sel && wr && addr && m_pop(b)) begin
      case (r)
        2: m_pw[b] = wdata;
        3: m_ctl[b] = wdata;
        5: m_en[b] = wdata;
        8: m_wlo[b] = wdata;
        9: m_whi[b] = wdata;
        default: ;
      endcase
    end
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    int crst_exp;
    crst_exp = 0;
    for (int s = 0; s < NS; s++) if (!m_ctl[s][7]) crst_exp |= (1 << s);
    chk({cur_req, " rdata"}, rdata, addr ? m_read(m_idx) : m_idx);
    chk({cur_req, " irq"}, irq, m_irq());
    chk({cur_req, " card_rst"}, crst, crst_exp);
  endtask

  task automatic tick();
    #1 compare();
    @(posedge clk);
    if (!rst_n) m_reset(); else m_step();
    @(negedge clk);
  endtask

  task automatic acc(bit w, bit a, int v);
    sel = 1; wr = w; addr = a; wdata = 8'(v);
    tick();
    sel = 0; wr = 0;
  endtask

  task automatic wreg(int i, int v);
    acc(1, 0, i);
    acc(1, 1, v);
  endtask

  task automatic rd_expect(int i, int exp, string req);
    acc(1, 0, i);
    sel = 1; wr = 0; addr = 1;
    #1 chk(req, rdata, exp);
    tick();
    sel = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_reset();
    @(negedge clk);
    tick(); tick();
    rst_n = 1;
    // R12 reset state
    cur_req = "R12";
    #1 chk("R12 index", rdata, 0);
    chk("R12 irq", irq, 0);
    chk("R10 reset held", crst, 4'hF);
    tick();

    cur_req = "R2";
    wreg(8'h02, 8'h15); wreg(8'h42, 8'h26); wreg(8'h82, 8'h37); wreg(8'hC2, 8'h48);
    rd_expect(8'h02, 8'h15, "R2 s0 pwr");
    rd_expect(8'h42, 8'h26, "R2 s1 pwr");
    rd_expect(8'h82, 8'h37, "R2 s2 pwr");
    rd_expect(8'hC2, 8'h48, "R2 s3 pwr");
    wreg(8'h47, 8'hAA);
    rd_expect(8'h47, 8'h00, "R2 undefined offset");
    cur_req = "R1";
    acc(1, 0, 8'h5A);
    addr = 0; #1 chk("R1 index readback", rdata, 8'h5A); tick();

    cur_req = "R3";
    wreg(8'h48, 8'h34); wreg(8'h49, 8'h12);
    rd_expect(8'h48, 8'h34, "R3 low byte");
    rd_expect(8'h49, 8'h12, "R3 high byte");

    cur_req = "R4";
    d1[2] = 1; d2[2] = 1; wp[2] = 1;
    tick();
    rd_expect(8'h81, 8'h5F, "R4 status present");
    s1[2] = 0;
    tick();
    rd_expect(8'h81, 8'h5E, "R7 low sense reads asserted");
    rd_expect(8'h84, 8'h09, "R4 detect and sense events");
    rd_expect(8'h84, 8'h00, "R5 cleared by read");

    cur_req = "R6";
    wreg(8'h05, 8'h07);
    s1[0] = 0; s2[0] = 0; rdy[0] = 1;
    tick();
    #1 chk("R11 irq raised", irq, 1); tick();
    rd_expect(8'h04, 8'h07, "R6 memory mode bits");
    #1 chk("R11 irq dropped after read", irq, 0); tick();

    cur_req = "R10";
    wreg(8'h03, 8'hA0);
    #1 chk("R10 reset released", crst[0], 0); tick();
    cur_req = "R6";
    s1[0] = 1; s2[0] = 1; rdy[0] = 0; tick();
    s2[0] = 0; rdy[0] = 1; tick();
    rd_expect(8'h04, 8'h00, "R6 io mode masks battery/ready");
    s1[0] = 0; tick();
    rd_expect(8'h04, 8'h01, "R6 io mode status change");

    cur_req = "R5";
    s1[0] = 1; tick();
    acc(1, 0, 8'h04);
    sel = 1; wr = 0; addr = 1; s1[0] = 0;
    #1 chk("R5 read before event", rdata, 0);
    tick(); sel = 0;
    rd_expect(8'h04, 8'h01, "R5 same-cycle event kept");

    cur_req = "R9";
    wreg(8'hC5, 8'h08);
    cfg = 2'b01; tick();
    wreg(8'h42, 8'h99);
    rd_expect(8'h42, 8'h00, "R9 unpopulated read zero");
    cfg = 2'b00; tick();
    cur_req = "R8";
    rd_expect(8'h42, 8'h26, "R8 two sockets, write ignored earlier");
    rd_expect(8'h82, 8'h00, "R8 socket2 absent with two");
    cur_req = "R9";
    d1[3] = 1; d2[3] = 1; tick(); tick();
    #1 chk("R9 no irq from absent socket", irq, 0); tick();
    cfg = 2'b11; tick();
    rd_expect(8'hC4, 8'h00, "R9 no event latched while absent");
    rd_expect(8'hC2, 8'h48, "R8 four sockets");
    cur_req = "R11";
    repeat (3) tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule